// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps calendar time in a bank of byte-wide registers. Seconds, minutes, hours, weekday, day of month, month and two-digit year are held as packed BCD counters (tens digit in bits 7:4, units digit in bits 3:0). A single-cycle pulse on the one-per-second enable advances them. Minutes, hours and the calendar fields roll over correctly, and month lengths include leap Februaries.

A host reaches the bank over a simple synchronous bus: address, write strobe and write data, plus a read strobe with registered read data. The top eight byte addresses of the address space hold the bank. A control byte provides two mechanisms. The update bit routes host writes into a shadow set that is committed in one cycle. The freeze bit holds the host-visible copy still so that a multi-byte read is coherent. A halt flag and two stored mode flags sit inside the time bytes themselves.

Top module: `rtc_bcd_bank`

## Requirements
- R1: After reset, the bank reads control 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day of month 0x01, month 0x01 and year 0x00.
- R2: The register offsets within the top eight addresses are control 0, seconds 1, minutes 2, hours 3, weekday 4, day of month 5, month 6 and year 7. Read data appears on the clock edge that samples the read strobe. Any address outside the bank reads 0x00.
- R3: Each tick advances seconds in BCD (09 goes to 10). Seconds 59 wrap to 00 and carry into minutes, and minutes 59 wrap to 00 and carry into hours.
- R4: Hours 23 wrap to 00 and carry into the day. The weekday goes from 7 back to 1, and the day of month advances.
- R5: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R6: February ends at day 29 when the year value is divisible by 4, and at day 28 otherwise.
- R7: Control bit 7 is the update bit. Setting it copies the running time into a shadow set. Time-register writes made while it is set change only the shadow set and do not show on reads. Clearing it loads the whole shadow set into the counters in one cycle, and a tick in that same cycle is discarded.
- R8: A write to a time register while the update bit is clear has no effect.
- R9: Control bit 6 is the freeze bit. While it is set, the host-visible time bytes hold still but the counters keep running. Once it clears, reads show the current count.
- R10: Bit 7 of the seconds byte is the halt flag. While it is set, ticks do not advance any counter.
- R11: Bit 7 of the hours byte and bit 6 of the weekday byte are read/write flags, and control bit 5 is a stored sign flag. Unused bits read as zero: hours bit 6, weekday bits 5:3, day bits 7:6, month bits 7:5, minutes bit 7 and control bits 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second that advances time |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach is a commit that coincides with a tick. The bench drives the control write that clears the update bit in the same cycle as a tick pulse, then checks that the committed seconds value is unchanged rather than one higher. Long carry chains such as the year wrap and the leap February are reached by staging a time one second before the boundary, never by counting up to it. The freeze case ticks several times while frozen, then compares the frozen reads with the reads taken after release.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic       kick;
    logic [5:0] hour;
    logic       ftest;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{stop: 1'b0, sec: 7'h00, min: 7'h00, kick: 1'b0,
                                      hour: 6'h00, ftest: 1'b0, dow: 3'd1, date: 6'h01,
                                      month: 5'h01, year: 8'h00};

  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_SEC   = 3'd1;
  localparam logic [2:0] IDX_MIN   = 3'd2;
  localparam logic [2:0] IDX_HOUR  = 3'd3;
  localparam logic [2:0] IDX_DOW   = 3'd4;
  localparam logic [2:0] IDX_DATE  = 3'd5;
  localparam logic [2:0] IDX_MONTH = 3'd6;
  localparam logic [2:0] IDX_YEAR  = 3'd7;

  // One BCD step with wrap from top back to low
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] low);
    if (v >= top)             return low;
    else if (v[3:0] >= 4'd9)  return {v[7:4] + 4'd1, 4'd0};
    else                      return v + 8'd1;
  endfunction

  // Last valid day of a month, BCD; leap when year mod 4 == 0 (10 = 2 mod 4)
  function automatic logic [7:0] month_last(input logic [4:0] mon, input logic [7:0] yr);
    logic [1:0] rem4;
    rem4 = {yr[4], 1'b0} + yr[1:0];
    case (mon)
      5'h02:                      return (rem4 == 2'd0) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] pack_reg(input rtc_time_t t, input logic [2:0] idx);
    case (idx)
      IDX_SEC:   return {t.stop, t.sec};
      IDX_MIN:   return {1'b0, t.min};
      IDX_HOUR:  return {t.kick, 1'b0, t.hour};
      IDX_DOW:   return {1'b0, t.ftest, 3'b000, t.dow};
      IDX_DATE:  return {2'b00, t.date};
      IDX_MONTH: return {3'b000, t.month};
      IDX_YEAR:  return t.year;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic rtc_time_t merge_write(input rtc_time_t t, input logic [2:0] idx,
                                            input logic [7:0] d);
    rtc_time_t r;
    r = t;
    case (idx)
      IDX_SEC:   begin r.stop = d[7]; r.sec = d[6:0]; end
      IDX_MIN:   r.min = d[6:0];
      IDX_HOUR:  begin r.kick = d[7]; r.hour = d[5:0]; end
      IDX_DOW:   begin r.ftest = d[6]; r.dow = d[2:0]; end
      IDX_DATE:  r.date = d[5:0];
      IDX_MONTH: r.month = d[4:0];
      IDX_YEAR:  r.year = d;
      default:   r = t;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t time_q
);

  rtc_time_t nxt;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;

  always_comb begin
    sec_wrap   = time_q.sec >= 7'h59;
    min_wrap   = time_q.min >= 7'h59;
    hour_wrap  = time_q.hour >= 6'h23;
    date_wrap  = {2'b00, time_q.date} >= month_last(time_q.month, time_q.year);
    month_wrap = time_q.month >= 5'h12;
    nxt        = time_q;
    nxt.sec    = bcd_step({1'b0, time_q.sec}, 8'h59, 8'h00)[6:0];  // R3
    if (sec_wrap) begin
      nxt.min = bcd_step({1'b0, time_q.min}, 8'h59, 8'h00)[6:0];
      if (min_wrap) begin
        nxt.hour = bcd_step({2'b00, time_q.hour}, 8'h23, 8'h00)[5:0];
        if (hour_wrap) begin                                       // R4
          nxt.dow  = (time_q.dow >= 3'd7) ? 3'd1 : time_q.dow + 3'd1;
          nxt.date = date_wrap ? 6'h01 : bcd_step({2'b00, time_q.date}, 8'h31, 8'h01)[5:0];
          if (date_wrap) begin                                     // R5 R6
            nxt.month = bcd_step({3'b000, time_q.month}, 8'h12, 8'h01)[4:0];
            if (month_wrap) nxt.year = bcd_step(time_q.year, 8'h99, 8'h00);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        time_q <= RTC_RESET;
    else if (load)                  time_q <= load_val;   // R7: commit wins over tick
    else if (tick && !time_q.stop)  time_q <= nxt;        // R10
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (time_q.stop && !load) |=> $stable(time_q)); // R10
  AST_COMMIT_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> (time_q == $past(load_val))); // R7
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !time_q.stop && time_q.sec == 7'h59) |=> (time_q.sec == 7'h00)); // R3

endmodule

// File: rtl/rtc_host_if.sv
module rtc_host_if
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  rtc_time_t         cur_time,
  output logic              load,
  output rtc_time_t         load_val
);

  localparam int SEL_W = ADDR_W - 3;

  logic       wr_mode_q, freeze_q, sign_q;
  rtc_time_t  stage_q, vis_q;
  logic [7:0] rdata_q;
  logic       sel, ctrl_wr, time_wr;
  logic [2:0] idx;

  assign sel     = (bus_addr[ADDR_W-1:3] == {SEL_W{1'b1}});
  assign idx     = bus_addr[2:0];
  assign ctrl_wr = bus_wr && sel && (idx == IDX_CTRL);
  assign time_wr = bus_wr && sel && (idx != IDX_CTRL);

  // R7: falling update bit commits the shadow set
  assign load     = ctrl_wr && wr_mode_q && !bus_wdata[7];
  assign load_val = stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_mode_q <= 1'b0;
      freeze_q  <= 1'b0;
      sign_q    <= 1'b0;
    end else if (ctrl_wr) begin
      wr_mode_q <= bus_wdata[7];
      freeze_q  <= bus_wdata[6];
      sign_q    <= bus_wdata[5];   // R11
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   stage_q <= RTC_RESET;
    else if (ctrl_wr && bus_wdata[7] && !wr_mode_q) stage_q <= cur_time;
    else if (time_wr && wr_mode_q)             stage_q <= merge_write(stage_q, idx, bus_wdata); // R8: else dropped
  end

  always_ff @(posedge clk) begin
    if (rst)            vis_q <= RTC_RESET;
    else if (!freeze_q) vis_q <= cur_time;   // R9
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= 8'h00;
    else if (bus_rd) begin
      if (!sel)                  rdata_q <= 8'h00;
      else if (idx == IDX_CTRL)  rdata_q <= {wr_mode_q, freeze_q, sign_q, 5'b00000};
      else                       rdata_q <= pack_reg(vis_q, idx);
    end
  end

  assign bus_rdata = rdata_q;

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    freeze_q |=> $stable(vis_q)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel) |=> (bus_rdata == 8'h00)); // R2
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!wr_mode_q && !ctrl_wr) |=> $stable(stage_q)); // R8

endmodule

// File: rtl/rtc_bcd_bank.sv
module rtc_bcd_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);

  rtc_time_t time_q, load_val;
  logic      load;

  rtc_host_if #(.ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cur_time(time_q), .load(load),
    .load_val(load_val)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .tick(tick_1hz), .load(load), .load_val(load_val),
    .time_q(time_q)
  );

endmodule

// File: tb/sim_rtc_bcd_bank.sv
module sim_rtc_bcd_bank;

  localparam logic [10:0] A_CTRL = 11'h7F8, A_SEC = 11'h7F9, A_MIN = 11'h7FA,
                          A_HOUR = 11'h7FB, A_DOW = 11'h7FC, A_DATE = 11'h7FD,
                          A_MON  = 11'h7FE, A_YEAR = 11'h7FF;

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rtc_bcd_bank #(.ADDR_W(11)) u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic bwrite(input logic [10:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; tick = tk;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic bread(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [10:0] a, input logic [7:0] e);
    logic [7:0] v;
    bread(a, v);
    chk(tag, v, e);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    bwrite(A_CTRL, 8'h80, 1'b0);
    bwrite(A_SEC, s, 1'b0);   bwrite(A_MIN, mi, 1'b0);  bwrite(A_HOUR, h, 1'b0);
    bwrite(A_DOW, dw, 1'b0);  bwrite(A_DATE, dt, 1'b0); bwrite(A_MON, mo, 1'b0);
    bwrite(A_YEAR, y, 1'b0);
    bwrite(A_CTRL, 8'h00, 1'b0);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", A_CTRL, 8'h00); expect_reg("R1 sec", A_SEC, 8'h00);
    expect_reg("R1 min", A_MIN, 8'h00);   expect_reg("R1 hour", A_HOUR, 8'h00);
    expect_reg("R1 dow", A_DOW, 8'h01);   expect_reg("R1 date", A_DATE, 8'h01);
    expect_reg("R1 month", A_MON, 8'h01); expect_reg("R1 year", A_YEAR, 8'h00);
    expect_reg("R2 unmapped", 11'h123, 8'h00);
  endtask

  task automatic t_seconds;
    set_time(8'h09, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h20);
    pulse(1); expect_reg("R3 units carry", A_SEC, 8'h10);
    set_time(8'h59, 8'h59, 8'h12, 8'h01, 8'h01, 8'h01, 8'h20);
    pulse(1);
    expect_reg("R3 sec wrap", A_SEC, 8'h00);
    expect_reg("R3 min wrap", A_MIN, 8'h00);
    expect_reg("R3 hour carry", A_HOUR, 8'h13);
  endtask

  task automatic t_day;
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h04, 8'h24);
    pulse(1);
    expect_reg("R4 hour wrap", A_HOUR, 8'h00);
    expect_reg("R4 dow wrap", A_DOW, 8'h01);
    expect_reg("R5 30-day month", A_DATE, 8'h01);
    expect_reg("R5 month step", A_MON, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h05, 8'h24);
    pulse(1); expect_reg("R5 31-day month", A_DATE, 8'h31);
  endtask

  task automatic t_year;
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
    pulse(1);
    expect_reg("R5 dow step", A_DOW, 8'h04);
    expect_reg("R5 date", A_DATE, 8'h01);
    expect_reg("R5 month wrap", A_MON, 8'h01);
    expect_reg("R5 year wrap", A_YEAR, 8'h00);
  endtask

  task automatic t_leap;
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    pulse(1); expect_reg("R6 leap 29th", A_DATE, 8'h29); expect_reg("R6 leap month", A_MON, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    pulse(1); expect_reg("R6 leap end", A_DATE, 8'h01); expect_reg("R6 leap march", A_MON, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    pulse(1); expect_reg("R6 common end", A_DATE, 8'h01); expect_reg("R6 common march", A_MON, 8'h03);
  endtask

  task automatic t_staging;
    set_time(8'h10, 8'h20, 8'h08, 8'h01, 8'h05, 8'h06, 8'h30);
    bwrite(A_CTRL, 8'h80, 1'b0);
    bwrite(A_SEC, 8'h30, 1'b0);
    bwrite(A_MIN, 8'h45, 1'b0);
    expect_reg("R7 staged hidden", A_SEC, 8'h10);
    expect_reg("R7 ctrl bit", A_CTRL, 8'h80);
    bwrite(A_CTRL, 8'h00, 1'b1);   // commit with simultaneous tick
    expect_reg("R7 commit sec no tick", A_SEC, 8'h30);
    expect_reg("R7 commit min", A_MIN, 8'h45);
    expect_reg("R7 untouched hour", A_HOUR, 8'h08);
  endtask

  task automatic t_ignored;
    bwrite(A_SEC, 8'h11, 1'b0);
    bwrite(A_YEAR, 8'h55, 1'b0);
    expect_reg("R8 sec ignored", A_SEC, 8'h30);
    expect_reg("R8 year ignored", A_YEAR, 8'h30);
  endtask

  task automatic t_freeze;
    set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    bwrite(A_CTRL, 8'h40, 1'b0);
    pulse(3);
    expect_reg("R9 frozen sec", A_SEC, 8'h00);
    expect_reg("R9 ctrl", A_CTRL, 8'h40);
    bwrite(A_CTRL, 8'h00, 1'b0);
    expect_reg("R9 released sec", A_SEC, 8'h03);
  endtask

  task automatic t_halt;
    set_time(8'h95, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    pulse(2);
    expect_reg("R10 halted", A_SEC, 8'h95);
    set_time(8'h15, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    pulse(1);
    expect_reg("R10 resumed", A_SEC, 8'h16);
  endtask

  task automatic t_flags;
    set_time(8'h00, 8'hFF, 8'hD2, 8'hFF, 8'hFF, 8'hE1, 8'h00);
    expect_reg("R11 hour kick, bit6 zero", A_HOUR, 8'h92);
    expect_reg("R11 dow ftest", A_DOW, 8'h47);
    expect_reg("R11 date mask", A_DATE, 8'h3F);
    expect_reg("R11 month mask", A_MON, 8'h01);
    expect_reg("R11 min mask", A_MIN, 8'h7F);
    bwrite(A_CTRL, 8'h3F, 1'b0);
    expect_reg("R11 sign stored", A_CTRL, 8'h20);
    bwrite(A_CTRL, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset; t_seconds; t_day; t_year; t_leap; t_staging; t_ignored;
    t_freeze; t_halt; t_flags;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule